// File: doc/BRIEF.md
# Clock Generator Power-Down Sequencer

This block controls a clock generator's low-power state. Its input is an asynchronous, active-low power-down request. A synchronizer cleans the request up first. When the request arrives, the block gates every output clock group low. It disables the crystal oscillator and the VCO only in the following cycle. While the request stays asserted, the block ignores the processor-stop and bus-stop inputs.

When the request is removed, the block enables the oscillator and the VCO again. It then counts a stabilization window of `WAKE_CYCLES` clock cycles, which by default stands for about 3 ms. After the window it enables the reference output, and one cycle later the clock groups. Every enable comes straight from a flip-flop, so each enable changes at most once per cycle and never glitches. A downstream clock gate therefore never sees a partial pulse.

The same wake sequence runs when the block comes out of reset. The analog oscillator and the PLL are outside this block. It drives only their enables.

Top module: `pd_sequencer`

## Requirements
- R1: During reset, osc_en_o and vco_en_o are 1, while ref_en_o and all clock-group enables are 0. After reset is released with no request, ref_en_o rises at the WAKE_CYCLES-th rising edge and the clock groups are enabled one edge later.
- R2: With SYNC_STAGES = 2, the request is seen only through a two-flop synchronizer. Once pd_ni is low, the enables are unchanged after the second rising edge. After the third rising edge, ref_en_o, cpu_en_o, bus_en_o and busf_en_o are all 0.
- R3: osc_en_o and vco_en_o go to 0 one edge after the clock enables went to 0. They are never turned off in the same edge as the clocks.
- R4: While osc_en_o is 0, ref_en_o and all clock-group enables are 0.
- R5: While the block is powered down or waiting for stabilization, the values of cpu_stop_ni and bus_stop_ni have no effect on any output.
- R6: After pd_ni returns high, osc_en_o and vco_en_o rise at the third edge. The clocks then stay off for WAKE_CYCLES edges. ref_en_o rises at the last of those edges, and the clock enables rise on the next edge.
- R7: In normal operation, ref_en_o and busf_en_o are 1. Every bit of cpu_en_o equals cpu_stop_ni and every bit of bus_en_o equals bus_stop_ni, each sampled at the previous edge (1 = running).
- R8: A request that is withdrawn while the clocks are being gated still completes the shutdown. The oscillator goes off for at least one cycle before the wake sequence starts.
- R9: A request that arrives during the stabilization wait returns the block to the off state. The next wake waits a full WAKE_CYCLES window again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sequencer clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pd_ni | input | 1 | Asynchronous active-low power-down request |
| cpu_stop_ni | input | 1 | Processor clock run control, 1 = running |
| bus_stop_ni | input | 1 | Bus clock run control, 1 = running |
| osc_en_o | output | 1 | Crystal oscillator enable |
| vco_en_o | output | 1 | VCO enable |
| ref_en_o | output | 1 | Reference output enable |
| cpu_en_o | output | CPU_W | Processor clock enables |
| bus_en_o | output | BUS_W | Stoppable bus clock enables |
| busf_en_o | output | 1 | Free-running bus clock enable |

## Verification
The bench sweeps all four combinations of the two stop inputs while the block runs. This shows that each group follows its own control and does not follow the other. It repeats the stop sweep while the block is powered down and during the stabilization window, where any output movement reveals a leak of the stop inputs past the override.

Three request patterns are applied, each checked at the exact edge where each enable should change:
- A long request separates correct synchronizer depth and shutdown order from an off-by-one in either.
- A one-cycle pulse shows whether a withdrawn request still completes the shutdown.
- A request that arrives during the stabilization wait shows whether the timer restarts or resumes.

// File: rtl/pd_sequencer_pkg.sv
package pd_sequencer_pkg;

  typedef enum logic [2:0] {
    ST_RUN       = 3'd0,
    ST_GATE_LOW  = 3'd1,
    ST_OSC_OFF   = 3'd2,
    ST_WAKE_WAIT = 3'd3,
    ST_RELEASE   = 3'd4
  } pd_state_e;

  typedef struct packed {
    logic osc;
    logic vco;
    logic refc;
    logic cpu;
    logic bus;
    logic busf;
  } pd_en_t;

  localparam pd_en_t EN_WAKE = '{osc: 1'b1, vco: 1'b1, refc: 1'b0,
                                 cpu: 1'b0, bus: 1'b0, busf: 1'b0};

endpackage

// File: rtl/pd_sync.sv
module pd_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pd_ni,
  output logic req_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], ~pd_ni};
  end

  assign req_o = sync_q[STAGES-1];
endmodule

// File: rtl/pd_wake_timer.sv
module pd_wake_timer #(
  parameter int unsigned WAKE_CYCLES = 300000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  localparam int unsigned CNT_W = $clog2(WAKE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WAKE_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!run_i)      cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/pd_fsm.sv
module pd_fsm
  import pd_sequencer_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   req_i,
  input  logic   wake_done_i,
  input  logic   cpu_run_i,
  input  logic   bus_run_i,
  output logic   wake_run_o,
  output pd_en_t en_o
);
  pd_state_e state_q, state_d;
  pd_en_t    en_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:       if (req_i) state_d = ST_GATE_LOW;
      ST_GATE_LOW:  state_d = ST_OSC_OFF; // shutdown always completes
      ST_OSC_OFF:   if (!req_i) state_d = ST_WAKE_WAIT;
      ST_WAKE_WAIT: if (req_i) state_d = ST_OSC_OFF;
                    else if (wake_done_i) state_d = ST_RELEASE;
      ST_RELEASE:   state_d = req_i ? ST_GATE_LOW : ST_RUN;
      default:      state_d = ST_WAKE_WAIT;
    endcase
  end

  // enables decoded from next state and registered: no decode glitches
  always_comb begin
    en_d = EN_WAKE;
    unique case (state_d)
      ST_RUN:      en_d = '{osc: 1'b1, vco: 1'b1, refc: 1'b1,
                            cpu: cpu_run_i, bus: bus_run_i, busf: 1'b1};
      ST_GATE_LOW: en_d = EN_WAKE;
      ST_OSC_OFF:  en_d = '0;
      ST_RELEASE:  en_d = '{osc: 1'b1, vco: 1'b1, refc: 1'b1,
                            cpu: 1'b0, bus: 1'b0, busf: 1'b0};
      default:     en_d = EN_WAKE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_WAKE_WAIT;
      en_o    <= EN_WAKE;
    end else begin
      state_q <= state_d;
      en_o    <= en_d;
    end
  end

  assign wake_run_o = (state_q == ST_WAKE_WAIT) && !req_i;
endmodule

// File: rtl/pd_sequencer.sv
module pd_sequencer
  import pd_sequencer_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned WAKE_CYCLES = 300000,
  parameter int unsigned CPU_W       = 2,
  parameter int unsigned BUS_W       = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pd_ni,
  input  logic             cpu_stop_ni,
  input  logic             bus_stop_ni,
  output logic             osc_en_o,
  output logic             vco_en_o,
  output logic             ref_en_o,
  output logic [CPU_W-1:0] cpu_en_o,
  output logic [BUS_W-1:0] bus_en_o,
  output logic             busf_en_o
);
  logic   req, wake_run, wake_done;
  pd_en_t en;

  pd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pd_ni (pd_ni),
    .req_o (req)
  );

  pd_wake_timer #(.WAKE_CYCLES(WAKE_CYCLES)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (wake_run),
    .done_o(wake_done)
  );

  pd_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req),
    .wake_done_i(wake_done),
    .cpu_run_i  (cpu_stop_ni),
    .bus_run_i  (bus_stop_ni),
    .wake_run_o (wake_run),
    .en_o       (en)
  );

  assign osc_en_o  = en.osc;
  assign vco_en_o  = en.vco;
  assign ref_en_o  = en.refc;
  assign busf_en_o = en.busf;

  for (genvar g = 0; g < CPU_W; g++) begin : g_cpu
    assign cpu_en_o[g] = en.cpu;
  end
  for (genvar g = 0; g < BUS_W; g++) begin : g_bus
    assign bus_en_o[g] = en.bus;
  end
endmodule

// File: rtl/pd_sequencer_chk.sv
module pd_sequencer_chk #(
  parameter int unsigned WAKE_CYCLES = 300000,
  parameter int unsigned CPU_W       = 2,
  parameter int unsigned BUS_W       = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pd_ni,
  input logic             osc_en_o,
  input logic             vco_en_o,
  input logic             ref_en_o,
  input logic [CPU_W-1:0] cpu_en_o,
  input logic [BUS_W-1:0] bus_en_o,
  input logic             busf_en_o
);
  logic [1:0]  since_rst_q;
  logic [31:0] osc_on_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_rst_q <= '0;
      osc_on_q    <= '0;
    end else begin
      if (since_rst_q != 2'd3) since_rst_q <= since_rst_q + 2'd1;
      if (!osc_en_o)                  osc_on_q <= '0;
      else if (osc_on_q != '1)        osc_on_q <= osc_on_q + 32'd1;
    end
  end

  AST_OFF_IS_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_en_o |-> (!ref_en_o && cpu_en_o == '0 && bus_en_o == '0 && !busf_en_o && !vco_en_o)); // R4

  AST_GATE_BEFORE_OSC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(osc_en_o) |-> ($past(cpu_en_o) == '0 && $past(bus_en_o) == '0 && !$past(busf_en_o))); // R3

  AST_ENTRY_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst_q == 2'd3 && !pd_ni && !$past(pd_ni) && !$past(pd_ni, 2))
      |=> (cpu_en_o == '0 && bus_en_o == '0 && !busf_en_o && !ref_en_o)); // R2

  AST_REF_LEADS_CLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busf_en_o) |-> $past(ref_en_o)); // R6

  AST_WAKE_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busf_en_o) |-> (osc_on_q >= WAKE_CYCLES)); // R6
endmodule

bind pd_sequencer pd_sequencer_chk #(
  .WAKE_CYCLES(WAKE_CYCLES), .CPU_W(CPU_W), .BUS_W(BUS_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .pd_ni    (pd_ni),
  .osc_en_o (osc_en_o),
  .vco_en_o (vco_en_o),
  .ref_en_o (ref_en_o),
  .cpu_en_o (cpu_en_o),
  .bus_en_o (bus_en_o),
  .busf_en_o(busf_en_o)
);

// File: tb/pd_sequencer_bench.sv
module pd_sequencer_bench;
  localparam int unsigned W     = 6;
  localparam int unsigned CPU_W = 2;
  localparam int unsigned BUS_W = 5;
  localparam int unsigned VW    = 4 + CPU_W + BUS_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pd_n = 1'b1;
  logic cpu_stop_n = 1'b1;
  logic bus_stop_n = 1'b1;
  logic osc_en, vco_en, ref_en, busf_en;
  logic [CPU_W-1:0] cpu_en;
  logic [BUS_W-1:0] bus_en;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pd_sequencer #(.SYNC_STAGES(2), .WAKE_CYCLES(W), .CPU_W(CPU_W), .BUS_W(BUS_W)) u_pd_sequencer (
    .clk_i(clk), .rst_ni(rst_n), .pd_ni(pd_n),
    .cpu_stop_ni(cpu_stop_n), .bus_stop_ni(bus_stop_n),
    .osc_en_o(osc_en), .vco_en_o(vco_en), .ref_en_o(ref_en),
    .cpu_en_o(cpu_en), .bus_en_o(bus_en), .busf_en_o(busf_en)
  );

  function automatic logic [VW-1:0] ex(logic o, logic v, logic r, logic c, logic b, logic f);
    return {o, v, r, {CPU_W{c}}, {BUS_W{b}}, f};
  endfunction

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [VW-1:0] exp);
    logic [VW-1:0] act;
    act = {osc_en, vco_en, ref_en, cpu_en, bus_en, busf_en};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    tick(3);
    chk("R1 reset", ex(1, 1, 0, 0, 0, 0));
    rst_n = 1'b1;
    tick(W - 1);
    chk("R1 wake hold", ex(1, 1, 0, 0, 0, 0));
    tick(1);
    chk("R1 ref first", ex(1, 1, 1, 0, 0, 0));
    tick(1);
    chk("R1 run", ex(1, 1, 1, 1, 1, 1));

    for (int i = 0; i < 4; i++) begin
      cpu_stop_n = i[0]; bus_stop_n = i[1];
      tick(1);
      chk("R7 stop sweep", ex(1, 1, 1, i[0], i[1], 1));
    end
    cpu_stop_n = 1'b1; bus_stop_n = 1'b1;
    tick(1);

    // R2 long request
    pd_n = 1'b0;
    tick(2);
    chk("R2 not yet", ex(1, 1, 1, 1, 1, 1));
    tick(1);
    chk("R2 gated", ex(1, 1, 0, 0, 0, 0));
    tick(1);
    chk("R3 osc off", ex(0, 0, 0, 0, 0, 0));
    for (int i = 0; i < 4; i++) begin
      cpu_stop_n = i[0]; bus_stop_n = i[1];
      tick(1);
      chk("R5 R4 off hold", ex(0, 0, 0, 0, 0, 0));
    end
    cpu_stop_n = 1'b1; bus_stop_n = 1'b1;

    // R6 exit
    pd_n = 1'b1;
    tick(2);
    chk("R6 still off", ex(0, 0, 0, 0, 0, 0));
    tick(1);
    chk("R6 osc on", ex(1, 1, 0, 0, 0, 0));
    for (int i = 0; i < 4; i++) begin
      cpu_stop_n = i[0]; bus_stop_n = i[1];
      tick(1);
      chk("R5 wake ignores stops", ex(1, 1, 0, 0, 0, 0));
    end
    cpu_stop_n = 1'b1; bus_stop_n = 1'b1;
    tick(W - 5);
    chk("R6 wait end", ex(1, 1, 0, 0, 0, 0));
    tick(1);
    chk("R6 ref on", ex(1, 1, 1, 0, 0, 0));
    tick(1);
    chk("R6 clocks on", ex(1, 1, 1, 1, 1, 1));
    tick(2);

    // R8 one-cycle request
    pd_n = 1'b0;
    tick(1);
    pd_n = 1'b1;
    tick(2);
    chk("R8 gated", ex(1, 1, 0, 0, 0, 0));
    tick(1);
    chk("R8 osc off", ex(0, 0, 0, 0, 0, 0));
    tick(1);
    chk("R8 wake", ex(1, 1, 0, 0, 0, 0));

    // R9 request during wait
    tick(2);
    pd_n = 1'b0;
    tick(2);
    chk("R9 wait continues", ex(1, 1, 0, 0, 0, 0));
    tick(1);
    chk("R9 back off", ex(0, 0, 0, 0, 0, 0));
    pd_n = 1'b1;
    tick(3);
    chk("R9 wake again", ex(1, 1, 0, 0, 0, 0));
    tick(W - 1);
    chk("R9 full window", ex(1, 1, 0, 0, 0, 0));
    tick(1);
    chk("R9 ref on", ex(1, 1, 1, 0, 0, 0));
    tick(1);
    chk("R9 run", ex(1, 1, 1, 1, 1, 1));

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule